// File: doc/BRIEF.md
# Memory-Card Socket Status and Identification Registers

This block sits on a simple word-addressed register bus of a baseboard. It returns two fixed words, one that identifies the board and one that describes the address decoding. It also reports the state of a memory-card socket. The write-protect sense line is shown live. A card insertion is caught as an event that stays pending until software acknowledges it. While an insertion is pending, the block drives one interrupt line.

Both socket lines are asynchronous, so each one passes through a synchroniser of `SYNC_STAGES` flops. An insertion is the rising edge of the synchronised card-detect line. A small two-state machine holds the pending event. In state `CD_EMPTY` no insertion is pending. In state `CD_PENDING` an insertion is waiting for software. Three transitions are named: ARM (`CD_EMPTY` to `CD_PENDING` on an insertion edge), ACK (`CD_PENDING` to `CD_EMPTY` on a clear write with no edge in the same cycle) and REARM (stay in `CD_PENDING` when an edge and a clear write arrive in the same cycle). Reads are combinational from the word address. Writes take effect on the clock edge.

Top module: `ccd_ctrl_top`

## Requirements
- R1: A read of word address 0 returns 0x41034003.
- R2: A read of word address 3 returns 0x00000011, and writes to it change nothing.
- R3: A read of word address 1 returns 0, and writes to it change nothing.
- R4: In the status word (word address 2), bit 0 equals the write-protect input as it was sampled `SYNC_STAGES` clock edges earlier. With the default of 2, this is the value present before the edge two cycles back.
- R5: Bit 3 of the status word becomes 1 one edge after the synchronised card-detect line rises. With the default of 2, this is three edges after the raw input is first sampled high. The bit stays 1 after the input falls. A line held high does not set it again.
- R6: A write to word address 2 whose data has bit 3 set clears the pending insertion. A write there with bit 3 clear has no effect. Bits other than bits 0 and 3 of the status word always read 0.
- R7: The interrupt output always equals bit 3 of the status word.
- R8: When an insertion edge and a clear write fall in the same cycle, the insertion stays pending.
- R9: Word addresses 4 and above read 0, and writes to them change no readable state.
- R10: After reset, no insertion is pending and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wp_raw | input | 1 | Write-protect sense from the socket (asynchronous) |
| cd_raw | input | 1 | Card-detect sense from the socket (asynchronous) |
| card_irq | output | 1 | Interrupt: high while an insertion is pending |

## Verification
The assertions assume that the bus address, the write strobe and the write data are known, valid values in every cycle after reset. They also assume that these bus inputs change only away from the rising clock edge, so that each write lands in exactly one cycle. The socket lines may change at any cycle. The properties watch the synchronised edge rather than the raw pin, so they do not depend on how long a pulse lasts. The stimulus drives every input just after the falling edge. It uses widths from single-cycle pulses to long holds, and it places a clear write on the exact cycle of an insertion edge.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int          DATA_W      = 32;
    localparam logic [31:0] ID_WORD     = 32'h4103_4003;
    localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
    localparam int          IDX_ID      = 0;
    localparam int          IDX_FLASH   = 1;
    localparam int          IDX_STATUS  = 2;
    localparam int          IDX_DECODE  = 3;
    localparam int          BIT_WP      = 0;
    localparam int          BIT_CD      = 3;

    typedef enum logic {
        CD_EMPTY   = 1'b0,
        CD_PENDING = 1'b1
    } cd_state_e;
endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ccd_edge.sv
module ccd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/ccd_insert_fsm.sv
module ccd_insert_fsm
    import ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pending
);
    cd_state_e state_q, state_d;

    // next state: ARM, ACK, REARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_EMPTY: begin
                if (set_evt) state_d = CD_PENDING;          // ARM
            end
            CD_PENDING: begin
                if (set_evt)      state_d = CD_PENDING;     // REARM, set wins
                else if (clr_evt) state_d = CD_EMPTY;       // ACK
            end
            default: state_d = CD_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CD_PENDING: pending = 1'b1;
            default:    pending = 1'b0;
        endcase
    end
endmodule

// File: rtl/ccd_readmux.sv
module ccd_readmux
    import ccd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_live,
    input  logic              cd_pending,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word         = '0;
        status_word[BIT_WP] = wp_live;
        status_word[BIT_CD] = cd_pending;
    end

    always_comb begin
        if      (addr == ADDR_W'(IDX_ID))     rdata = ID_WORD;
        else if (addr == ADDR_W'(IDX_FLASH))  rdata = '0;
        else if (addr == ADDR_W'(IDX_STATUS)) rdata = status_word;
        else if (addr == ADDR_W'(IDX_DECODE)) rdata = DECODE_WORD;
        else                                  rdata = '0;
    end
endmodule

// File: rtl/ccd_ctrl_top.sv
module ccd_ctrl_top
    import ccd_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wp_raw,
    input  logic              cd_raw,
    output logic              card_irq
);
    localparam int SOCK_W = 2;

    logic [SOCK_W-1:0] sock_sync;
    logic              cd_rise;
    logic              clr_evt;
    logic              cd_pending;
    logic              unused_wdata;

    ccd_sync #(.WIDTH(SOCK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cd_raw, wp_raw}),
        .q     (sock_sync)
    );

    ccd_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sock_sync[1]),
        .rise  (cd_rise)
    );

    assign clr_evt = bus_wr && (bus_addr == ADDR_W'(IDX_STATUS)) && bus_wdata[BIT_CD];
    assign unused_wdata = ^{bus_wdata[31:BIT_CD+1], bus_wdata[BIT_CD-1:0]};

    ccd_insert_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (cd_rise),
        .clr_evt (clr_evt),
        .pending (cd_pending)
    );

    ccd_readmux #(.ADDR_W(ADDR_W)) u_rd (
        .addr       (bus_addr),
        .wp_live    (sock_sync[0]),
        .cd_pending (cd_pending),
        .rdata      (bus_rdata)
    );

    assign card_irq = cd_pending;
endmodule

// File: rtl/ccd_ctrl_chk.sv
module ccd_ctrl_chk
    import ccd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              card_irq,
    input logic              cd_rise
);
    logic clr_req;
    assign clr_req = bus_wr && (bus_addr == ADDR_W'(IDX_STATUS)) && bus_wdata[BIT_CD];

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(IDX_ID) |-> bus_rdata == ID_WORD); // R1
    AST_DECODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(IDX_DECODE) |-> bus_rdata == DECODE_WORD); // R2
    AST_FLASH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(IDX_FLASH) |-> bus_rdata == '0); // R3
    AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cd_rise |=> card_irq); // R5
    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq && !clr_req |=> card_irq); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !card_irq && !cd_rise |=> !card_irq); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !cd_rise |=> !card_irq); // R6
    AST_STATUS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(IDX_STATUS) |-> (bus_rdata & 32'hFFFF_FFF6) == '0); // R6
    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(IDX_STATUS) |-> bus_rdata[BIT_CD] == card_irq); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cd_rise && clr_req |=> card_irq); // R8
    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr > ADDR_W'(IDX_DECODE) |-> bus_rdata == '0); // R9
endmodule

bind ccd_ctrl_top ccd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .card_irq  (card_irq),
    .cd_rise   (cd_rise)
);

// File: tb/ccd_ctrl_top_tb.sv
module ccd_ctrl_top_tb;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          wp_raw = 1'b0;
    logic          cd_raw = 1'b0;
    logic          card_irq;

    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R10";

    // behavioural reference state
    bit m_wp_q[$];
    bit m_cd_q[$];
    bit m_cd_prev;
    bit m_pend;

    always #10 clk = ~clk; // 50 MHz

    ccd_ctrl_top #(.ADDR_W(AW)) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .wp_raw (wp_raw), .cd_raw (cd_raw), .card_irq (card_irq)
    );

    initial begin
        m_wp_q = '{0, 0};
        m_cd_q = '{0, 0};
    end

    always @(posedge clk) begin
        bit rise, clr, cd_now;
        if (!rst_n) begin
            m_wp_q = '{0, 0};
            m_cd_q = '{0, 0};
            m_cd_prev = 0;
            m_pend = 0;
        end else begin
            cd_now = m_cd_q[0];
            rise = cd_now && !m_cd_prev;
            clr  = bus_wr && bus_addr == 2 && bus_wdata[3];
            if (rise)     m_pend = 1;
            else if (clr) m_pend = 0;
            m_cd_prev = cd_now;
            void'(m_cd_q.pop_front());
            m_cd_q.push_back(cd_raw);
            void'(m_wp_q.pop_front());
            m_wp_q.push_back(wp_raw);
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check("R7 irq", {31'b0, card_irq}, {31'b0, m_pend});
        case (bus_addr)
            0: check("R1", bus_rdata, 32'h4103_4003);
            1: check("R3", bus_rdata, 32'h0);
            2: begin
                check("R4 wp bit", {31'b0, bus_rdata[0]}, {31'b0, m_wp_q[0]});
                check({phase, " cd bit"}, {31'b0, bus_rdata[3]}, {31'b0, m_pend});
                check("R6 spare bits", bus_rdata & 32'hFFFF_FFF6, 32'h0);
            end
            3: check("R2", bus_rdata, 32'h11);
            default: check("R9", bus_rdata, 32'h0);
        endcase
    end

    task automatic step(bit wr, int addr, logic [31:0] wd, bit wp, bit cd);
        @(negedge clk);
        #1;
        bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd; wp_raw = wp; cd_raw = cd;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R10: reset state
        bus_addr = 2;
        repeat (4) @(posedge clk);
        step(0, 2, 0, 0, 0);
        rst_n = 1'b1;
        step(0, 2, 0, 0, 0);
        // R1 R2 R3 R9 fixed words
        for (int a = 0; a < 64; a += 7) step(0, a, 0, 0, 0);
        step(0, 3, 0, 0, 0);
        // writes to read-only and unknown words have no effect (R2 R3 R9)
        step(1, 1, 32'hFFFF_FFFF, 0, 0);
        step(1, 3, 32'hFFFF_FFFF, 0, 0);
        step(1, 9, 32'hFFFF_FFFF, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 3, 0, 0, 0);
        step(0, 9, 0, 0, 0);
        step(0, 2, 0, 0, 0);
        // R4 write-protect follows the input
        phase = "R4";
        for (int i = 0; i < 8; i++) step(0, 2, 0, i[1], 0);
        // R5 single-cycle insertion pulse, then input drops
        phase = "R5";
        step(0, 2, 0, 0, 1);
        for (int i = 0; i < 6; i++) step(0, 2, 0, 0, 0);
        // R6 write without bit 3 does nothing, then acknowledge
        phase = "R6";
        step(1, 2, 32'hFFFF_FFF7, 0, 0);
        step(0, 2, 0, 0, 0);
        step(1, 2, 32'h8, 0, 0);
        step(0, 2, 0, 0, 0);
        // R5 held-high line arms once; a clear while held leaves it clear
        phase = "R5";
        for (int i = 0; i < 5; i++) step(0, 2, 0, 0, 1);
        step(1, 2, 32'h8, 0, 1);
        for (int i = 0; i < 5; i++) step(0, 2, 0, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 2, 0, 0, 0);
        // R8 edge and clear in the same cycle: edge comes two edges after raw rise
        phase = "R8";
        step(0, 2, 0, 0, 1);
        step(0, 2, 0, 0, 1);
        step(1, 2, 32'h8, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 2, 0, 0, 1);
        // R8 repeat while already pending
        for (int i = 0; i < 4; i++) step(0, 2, 0, 0, 0);
        step(0, 2, 0, 0, 1);
        step(0, 2, 0, 0, 1);
        step(1, 2, 32'h8, 0, 1);
        step(0, 2, 0, 0, 1);
        // mixed pattern for R4 R5 R6 R7 R9
        phase = "R5 R6 mix";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] ? 2 : int'(lfsr[7:2]), {28'b0, lfsr[4], 3'b0} | {lfsr[11:9], 29'b0},
                 lfsr[5], lfsr[6] & lfsr[8]);
        end
        step(0, 2, 0, 0, 0);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule